// File: doc/BRIEF.md
# Eight-Channel Conversion Sequencer with Result FIFO

This block sits between a configuration source and an analog-to-digital converter core that handles eight inputs. It decides which input is converted next, raises a conversion request, and takes each result from a conversion-done pulse. In sweep modes it walks one of four fixed channel orders and stores the results in an eight-entry FIFO. In the single-channel modes it bypasses the FIFO and keeps one result register. A single active-low status pin serves either as an interrupt or as a conversion-in-progress indicator.

A host writes one 12-bit configuration word and pulses `start`. The converter core sees `conv_req` and `chan_sel`, and answers with `conv_done` and `conv_data`. The host drains sweep results through `fifo_rd` and `fifo_rdata`. A 2-bit trigger field sets both the sweep length and the FIFO fill level at which the interrupt fires.

The controller has three states. `ST_IDLE` waits for an accepted start. `ST_CONVERT` keeps the request raised and advances on each done pulse. `ST_HOLD` is used only by repeat sweep, which parks there until the FIFO is empty.

The transitions are:
- idle-to-convert: on an accepted start.
- convert-to-idle: at the end of a single conversion, at the end of a one-pass sweep, or on a configuration write.
- convert-to-hold: when a repeat sweep finishes its pass.
- hold-to-convert: when the FIFO is empty.
- hold-to-idle: on a configuration write.

Top module: `conv_sequencer`

## Requirements
- R1: After reset the outputs are as follows. `conv_req`, `seq_busy`, `fifo_underflow`, `fifo_level`, `fifo_rdata` and `direct_data` are all 0, and `stat_n` is 1.
- R2: The configuration word is laid out as follows:
  - bits [11:9]: channel for the single-channel modes.
  - bits [8:7]: ignored.
  - bits [6:5]: mode, where 00 is single shot, 01 is repeat, 10 is sweep and 11 is repeat sweep.
  - bits [4:3]: sweep order.
  - bit [2]: status-pin function.
  - bits [1:0]: trigger level.
- R3: In single-shot mode an accepted start converts the configured channel once. The result goes to `direct_data` and `fifo_level` does not change. Further starts are ignored until the next configuration write.
- R4: In repeat mode every start received while idle converts the configured channel again, and the new result overwrites `direct_data`.
- R5: In sweep modes, pass entry i uses a channel set by the sweep order field:
  - order 00: i.
  - order 01: 0,2,4,6,0,2,4,6.
  - order 10: 0,0,2,2,4,4,6,6.
  - order 11: 0,2,0,2,0,2,0,2.
- R6: The trigger field sets the pass length and the interrupt threshold. The values are 8 for 00, 6 for 01, 4 for 10 and 2 for 11.
- R7: In sweep mode (10) the block returns to idle after one pass. `seq_busy` drops and no further request is made until the next start.
- R8: In repeat-sweep mode (11) the block holds after a pass with no request raised. Once the FIFO reads empty it restarts the pass from entry 0.
- R9: When the pin function bit is 0, `stat_n` acts as an interrupt.
  - Sweep modes: `stat_n` is low while `fifo_level` is at or above the pass length.
  - Single-channel modes: `stat_n` is low from a result until the next accepted start or configuration write.
- R10: When the pin function bit is 1, `stat_n` is low exactly while `conv_req` is high.
- R11: A `fifo_rd` with a non-empty FIFO places the oldest result on `fifo_rdata` one cycle later and decrements `fifo_level`. A read of an empty FIFO leaves `fifo_rdata` unchanged and sets a sticky `fifo_underflow`, which is cleared by a configuration write.
- R12: A configuration write takes effect on the next cycle. It drops any conversion request, returns the block to idle and empties the FIFO.
- R13: A `conv_done` while `conv_req` is low is ignored. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 12 | Configuration word |
| start | input | 1 | Start strobe |
| conv_done | input | 1 | Conversion finished pulse from the converter core |
| conv_data | input | DATA_W | Result accompanying `conv_done` |
| fifo_rd | input | 1 | FIFO read strobe |
| chan_sel | output | 3 | Channel to convert |
| conv_req | output | 1 | Conversion request to the core |
| direct_data | output | DATA_W | Result register for the single-channel modes |
| fifo_rdata | output | DATA_W | FIFO read data |
| fifo_level | output | LVL_W | Number of results held in the FIFO |
| fifo_underflow | output | 1 | Sticky empty-read flag |
| seq_busy | output | 1 | Controller is not idle |
| stat_n | output | 1 | Shared active-low interrupt or conversion indicator |

## Verification
Timing is counted from the clock edge that samples a strobe:
- A sampled `start` or `cfg_we` changes `conv_req`, `seq_busy` and `stat_n` (in its conversion role) right after that edge.
- A sampled `conv_done` updates `fifo_level`, `direct_data` and `chan_sel` right after that edge.
- A sampled `fifo_rd` presents `fifo_rdata` right after that edge.

The bench drives every strobe for one cycle starting on a falling edge. It samples all outputs on the following falling edge, which is the first point where the registered result is due. Converter responses come from a bench model that logs the channel and result of every conversion it answers. Sweep checks wait for `seq_busy` to fall, or for the FIFO to reach the pass length, and then compare the log against the expected order.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int CFG_W = 12;
    localparam int CH_W  = 3;
    localparam int N_CH  = 1 << CH_W;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONVERT = 2'd1,
        ST_HOLD    = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_REPEAT = 2'b01,
        MODE_SWEEP  = 2'b10,
        MODE_RSWEEP = 2'b11
    } seq_mode_t;

    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic [1:0]      spare;
        seq_mode_t       mode;
        logic [1:0]      order;
        logic            pin_eoc;
        logic [1:0]      trig;
    } seq_cfg_t;

    // Channel used at pass entry idx for a given order code
    function automatic logic [CH_W-1:0] order_chan(input logic [1:0] ord,
                                                   input logic [CH_W-1:0] idx);
        logic [CH_W-1:0] ch;
        unique case (ord)
            2'b00:   ch = idx;
            2'b01:   ch = {idx[1:0], 1'b0};
            2'b10:   ch = {idx[2:1], 1'b0};
            default: ch = {1'b0, idx[0], 1'b0};
        endcase
        return ch;
    endfunction

    // Pass length / trigger threshold: 8, 6, 4, 2
    function automatic logic [3:0] pass_len(input logic [1:0] trig);
        return 4'd8 - {1'b0, trig, 1'b0};
    endfunction

endpackage

// File: rtl/seq_fifo.sv
module seq_fifo #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [$clog2(DEPTH):0] level_o,
    output logic              underflow_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic              do_rd, do_wr;

    assign do_rd = rd_en_i && (level_o != '0);
    assign do_wr = wr_en_i && ((level_o != FULL_LVL) || do_rd);

    always_ff @(posedge clk) begin
        if (do_wr && !flush_i) begin
            mem[wp] <= wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp          <= '0;
            rp          <= '0;
            level_o     <= '0;
            rd_data_o   <= '0;
            underflow_o <= 1'b0;
        end else if (flush_i) begin
            wp          <= '0;
            rp          <= '0;
            level_o     <= '0;
            underflow_o <= 1'b0;
        end else begin
            if (do_wr) begin
                wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
            end
            if (do_rd) begin
                rd_data_o <= mem[rp];
                rp        <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
            end
            if (rd_en_i && (level_o == '0)) begin
                underflow_o <= 1'b1;
            end
            unique case ({do_wr, do_rd})
                2'b10:   level_o <= level_o + 1'b1;
                2'b01:   level_o <= level_o - 1'b1;
                default: level_o <= level_o;
            endcase
        end
    end

    // R11
    level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= FULL_LVL);

    // R11
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (level_o == '0) && !flush_i) |=> ($stable(rd_data_o) && underflow_o));

endmodule

// File: rtl/seq_status.sv
module seq_status #(
    parameter int LW = 4
) (
    input  logic          pin_eoc_i,
    input  logic          sweep_i,
    input  logic          conv_req_i,
    input  logic          pending_i,
    input  logic [LW-1:0] level_i,
    input  logic [LW-1:0] pass_len_i,
    output logic          stat_n_o
);
    logic int_active;

    always_comb begin
        if (sweep_i) begin
            int_active = (level_i >= pass_len_i);
        end else begin
            int_active = pending_i;
        end
        if (pin_eoc_i) begin
            stat_n_o = !conv_req_i;
        end else begin
            stat_n_o = !int_active;
        end
    end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int LW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    input  logic              start_i,
    input  logic              conv_done_i,
    input  logic [DATA_W-1:0] conv_data_i,
    input  logic [LW-1:0]     fifo_level_i,
    output seq_cfg_t          cfg_o,
    output logic [CH_W-1:0]   chan_sel_o,
    output logic              conv_req_o,
    output logic              busy_o,
    output logic              fifo_wr_o,
    output logic              sweep_o,
    output logic              pending_o,
    output logic [LW-1:0]     pass_len_o,
    output logic [DATA_W-1:0] direct_o
);
    seq_state_t      state, state_nx;
    logic [CH_W-1:0] idx;
    logic            armed;
    logic            accept_done;
    logic            start_ok;
    logic            last_entry;
    logic            launch;

    assign sweep_o     = cfg_o.mode[1];
    assign pass_len_o  = LW'(pass_len(cfg_o.trig));
    assign accept_done = (state == ST_CONVERT) && conv_done_i && !cfg_we_i;
    assign last_entry  = ((LW'(idx) + 1'b1) == pass_len_o);
    assign start_ok    = start_i && !cfg_we_i &&
                         (sweep_o || (cfg_o.mode == MODE_REPEAT) ||
                          ((cfg_o.mode == MODE_SINGLE) && armed));
    assign launch      = (state == ST_IDLE) && (state_nx == ST_CONVERT);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_ok) state_nx = ST_CONVERT;
            end
            ST_CONVERT: begin
                if (cfg_we_i) begin
                    state_nx = ST_IDLE;
                end else if (accept_done) begin
                    if (!sweep_o) begin
                        state_nx = ST_IDLE;
                    end else if (last_entry) begin
                        state_nx = (cfg_o.mode == MODE_RSWEEP) ? ST_HOLD : ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                if (cfg_we_i) begin
                    state_nx = ST_IDLE;
                end else if (fifo_level_i == '0) begin
                    state_nx = ST_CONVERT;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Configuration, sequence index and result bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_o     <= '0;
            idx       <= '0;
            armed     <= 1'b1;
            pending_o <= 1'b0;
            direct_o  <= '0;
        end else if (cfg_we_i) begin
            cfg_o     <= seq_cfg_t'(cfg_wdata_i);
            idx       <= '0;
            armed     <= 1'b1;
            pending_o <= 1'b0;
        end else begin
            if (launch) begin
                idx       <= '0;
                pending_o <= 1'b0;
                if (cfg_o.mode == MODE_SINGLE) armed <= 1'b0;
            end else if ((state == ST_HOLD) && (state_nx == ST_CONVERT)) begin
                idx <= '0;
            end else if (accept_done && sweep_o && !last_entry) begin
                idx <= idx + 1'b1;
            end
            if (accept_done && !sweep_o) begin
                direct_o  <= conv_data_i;
                pending_o <= 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        conv_req_o = (state == ST_CONVERT);
        busy_o     = (state != ST_IDLE);
        fifo_wr_o  = accept_done && sweep_o;
        chan_sel_o = sweep_o ? order_chan(cfg_o.order, idx) : cfg_o.chan;
    end

    // R12
    cfg_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> ((state == ST_IDLE) && !conv_req_o));

    // R13
    stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done_i && (state != ST_CONVERT) && !cfg_we_i) |=> $stable(direct_o));

    // R7
    sweep_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CONVERT) && (cfg_o.mode == MODE_SWEEP) && conv_done_i
         && last_entry && !cfg_we_i) |=> (state == ST_IDLE));

    // R8
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HOLD) && (fifo_level_i != '0) && !cfg_we_i) |=> !conv_req_o);

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import seq_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int FIFO_DEPTH = 8,
    parameter int LVL_W      = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              fifo_rd,
    output logic [CH_W-1:0]   chan_sel,
    output logic              conv_req,
    output logic [DATA_W-1:0] direct_data,
    output logic [DATA_W-1:0] fifo_rdata,
    output logic [LVL_W-1:0]  fifo_level,
    output logic              fifo_underflow,
    output logic              seq_busy,
    output logic              stat_n
);
    seq_cfg_t           cfg_q;
    logic               fifo_wr;
    logic               sweep;
    logic               pending;
    logic [LVL_W-1:0]   plen;

    seq_ctrl #(.DATA_W(DATA_W), .LW(LVL_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we_i     (cfg_we),
        .cfg_wdata_i  (cfg_wdata),
        .start_i      (start),
        .conv_done_i  (conv_done),
        .conv_data_i  (conv_data),
        .fifo_level_i (fifo_level),
        .cfg_o        (cfg_q),
        .chan_sel_o   (chan_sel),
        .conv_req_o   (conv_req),
        .busy_o       (seq_busy),
        .fifo_wr_o    (fifo_wr),
        .sweep_o      (sweep),
        .pending_o    (pending),
        .pass_len_o   (plen),
        .direct_o     (direct_data)
    );

    seq_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (cfg_we),
        .wr_en_i     (fifo_wr),
        .wr_data_i   (conv_data),
        .rd_en_i     (fifo_rd),
        .rd_data_o   (fifo_rdata),
        .level_o     (fifo_level),
        .underflow_o (fifo_underflow)
    );

    seq_status #(.LW(LVL_W)) u_stat (
        .pin_eoc_i  (cfg_q.pin_eoc),
        .sweep_i    (sweep),
        .conv_req_i (conv_req),
        .pending_i  (pending),
        .level_i    (fifo_level),
        .pass_len_i (plen),
        .stat_n_o   (stat_n)
    );

    // R12
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (fifo_level == '0));

    // R3
    single_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sweep && !cfg_we && !fifo_rd) |=> $stable(fifo_level));

endmodule

// File: tb/sim_conv_sequencer.sv
module sim_conv_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;
    // {cfg[11:0], pass length[3:0], channel per entry as nibbles, entry 0 lowest}
    localparam logic [47:0] VEC [NVEC] = '{
        48'h040_8_76543210,
        48'h048_8_64206420,
        48'h050_8_66442200,
        48'h058_8_20202020,
        48'h041_6_00543210,
        48'h04A_4_00006420,
        48'h053_2_00000000,
        48'h05A_4_00002020,
        48'hFC0_8_76543210
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [11:0] cfg_wdata = 0;
    logic        start = 0;
    logic        conv_done = 0;
    logic [11:0] conv_data = 0;
    logic        fifo_rd = 0;
    logic [2:0]  chan_sel;
    logic        conv_req;
    logic [11:0] direct_data;
    logic [11:0] fifo_rdata;
    logic [3:0]  fifo_level;
    logic        fifo_underflow;
    logic        seq_busy;
    logic        stat_n;

    int nchk = 0;
    int nerr = 0;
    int log_n = 0;
    logic [2:0]  log_ch  [256];
    logic [11:0] log_res [256];
    logic model_en = 1;
    int stray_cnt = 0;
    int stray_seen = 0;
    int dly = 0;

    conv_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .start(start), .conv_done(conv_done), .conv_data(conv_data),
        .fifo_rd(fifo_rd), .chan_sel(chan_sel), .conv_req(conv_req),
        .direct_data(direct_data), .fifo_rdata(fifo_rdata),
        .fifo_level(fifo_level), .fifo_underflow(fifo_underflow),
        .seq_busy(seq_busy), .stat_n(stat_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Converter core model: answers each request two falling edges later
    initial begin
        forever begin
            @(negedge clk);
            if (conv_done) begin
                conv_done = 0;
            end else if (stray_seen != stray_cnt) begin
                stray_seen = stray_seen + 1;
                conv_done  = 1;
                conv_data  = 12'hABC;
            end else if (!conv_req) begin
                dly = 0;
            end else if (model_en) begin
                if (dly == 1) begin
                    conv_data = {chan_sel, 9'(log_n)};
                    log_ch[log_n % 256]  = chan_sel;
                    log_res[log_n % 256] = {chan_sel, 9'(log_n)};
                    log_n = log_n + 1;
                    conv_done = 1;
                    dly = 0;
                end else begin
                    dly = dly + 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [11:0] w);
        @(negedge clk); cfg_we = 1; cfg_wdata = w;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic fifo_read();
        @(negedge clk); fifo_rd = 1;
        @(negedge clk); fifo_rd = 0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 500 && seq_busy; k++) @(negedge clk);
    endtask

    task automatic wait_level(input logic [3:0] lv);
        for (int k = 0; k < 500 && fifo_level != lv; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int base;
        logic [11:0] prev;
        logic [11:0] cfg;
        logic [3:0]  len;
        logic [31:0] chans;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 conv_req", 32'(conv_req), 0);
        chk("R1 busy", 32'(seq_busy), 0);
        chk("R1 level", 32'(fifo_level), 0);
        chk("R1 stat_n", 32'(stat_n), 1);
        chk("R1 rdata", 32'(fifo_rdata), 0);
        chk("R1 direct", 32'(direct_data), 0);
        chk("R1 underflow", 32'(fifo_underflow), 0);

        // R11 empty read
        fifo_read();
        chk("R11 empty rdata", 32'(fifo_rdata), 0);
        chk("R11 underflow set", 32'(fifo_underflow), 1);

        // Sweep vectors: R2 R5 R6 R7 R9 R11 R13
        for (int v = 0; v < NVEC; v++) begin
            cfg   = VEC[v][47:36];
            len   = VEC[v][35:32];
            chans = VEC[v][31:0];
            cfg_write(cfg);
            chk("R11 underflow cleared", 32'(fifo_underflow), 0);
            base = log_n;
            pulse_start();
            repeat (3) @(negedge clk);
            pulse_start();   // R13 start while busy ignored
            wait_idle();
            chk("R6 R13 pass length", 32'(log_n - base), 32'(len));
            for (int i = 0; i < int'(len); i++)
                chk("R5 R2 channel order", 32'(log_ch[(base + i) % 256]), 32'(chans[4*i +: 3]));
            chk("R6 level", 32'(fifo_level), 32'(len));
            chk("R9 int low", 32'(stat_n), 0);
            repeat (3) @(negedge clk);
            chk("R7 no restart", 32'(conv_req), 0);
            chk("R7 busy low", 32'(seq_busy), 0);
            for (int i = 0; i < int'(len); i++) begin
                fifo_read();
                chk("R11 read data", 32'(fifo_rdata), 32'(log_res[(base + i) % 256]));
                if (i == 0) chk("R9 int released", 32'(stat_n), 1);
            end
            chk("R11 drained", 32'(fifo_level), 0);
        end

        // R11 empty read keeps last value
        prev = fifo_rdata;
        fifo_read();
        chk("R11 hold last", 32'(fifo_rdata), 32'(prev));
        chk("R11 underflow sticky", 32'(fifo_underflow), 1);

        // R3 single shot, channel 5
        cfg_write(12'hA00);
        base = log_n;
        pulse_start();
        wait_idle();
        chk("R3 one conversion", 32'(log_n - base), 1);
        chk("R3 direct data", 32'(direct_data), 32'(log_res[base % 256]));
        chk("R3 channel", 32'(direct_data[11:9]), 5);
        chk("R3 fifo bypass", 32'(fifo_level), 0);
        chk("R9 single int", 32'(stat_n), 0);
        pulse_start();
        repeat (4) @(negedge clk);
        chk("R3 rearm needed", 32'(log_n - base), 1);

        // R4 repeat, channel 3
        cfg_write(12'h620);
        chk("R9 int cleared by cfg", 32'(stat_n), 1);
        base = log_n;
        pulse_start();
        wait_idle();
        chk("R4 first", 32'(direct_data), 32'(log_res[base % 256]));
        chk("R4 channel", 32'(log_ch[base % 256]), 3);
        pulse_start();
        wait_idle();
        chk("R4 overwrite", 32'(direct_data), 32'(log_res[(base + 1) % 256]));
        chk("R4 channel again", 32'(log_ch[(base + 1) % 256]), 3);

        // R13 stray done while idle
        prev = direct_data;
        stray_cnt = stray_cnt + 1;
        repeat (4) @(negedge clk);
        chk("R13 stray direct", 32'(direct_data), 32'(prev));
        chk("R13 stray level", 32'(fifo_level), 0);

        // R10 status as conversion indicator, R12 abort
        model_en = 0;
        cfg_write(12'h424);
        chk("R10 idle high", 32'(stat_n), 1);
        pulse_start();
        repeat (2) @(negedge clk);
        chk("R10 req", 32'(conv_req), 1);
        chk("R10 pin low", 32'(stat_n), 0);
        cfg_write(12'h424);
        chk("R12 abort req", 32'(conv_req), 0);
        chk("R12 abort busy", 32'(seq_busy), 0);
        chk("R10 pin high", 32'(stat_n), 1);
        model_en = 1;
        base = log_n;
        pulse_start();
        wait_idle();
        chk("R10 pin after", 32'(stat_n), 1);
        chk("R4 channel 2", 32'(log_ch[base % 256]), 2);

        // R8 repeat sweep, order 01, length 4
        cfg_write(12'h06A);
        base = log_n;
        pulse_start();
        wait_level(4);
        repeat (4) @(negedge clk);
        chk("R8 hold level", 32'(fifo_level), 4);
        chk("R8 hold busy", 32'(seq_busy), 1);
        chk("R8 hold no req", 32'(conv_req), 0);
        chk("R9 rsweep int", 32'(stat_n), 0);
        for (int i = 0; i < 4; i++) begin
            fifo_read();
            chk("R8 R11 data", 32'(fifo_rdata), 32'(log_res[(base + i) % 256]));
        end
        wait_level(4);
        for (int i = 0; i < 4; i++)
            chk("R8 second pass", 32'(log_ch[(base + 4 + i) % 256]), 32'((2 * i) % 8));
        repeat (2) @(negedge clk);
        cfg_write(12'h040);
        chk("R12 flush", 32'(fifo_level), 0);
        chk("R12 idle", 32'(seq_busy), 0);

        finish_run();
    end
endmodule